// File: doc/BRIEF.md
# Temporal Dither Colour Depth Reducer

This block narrows a stream of 24-bit RGB pixels to 18 bits so that it can drive a panel with six data bits per colour. Each channel keeps its upper six bits as a base value. The two bits that are cut off are not simply dropped. The block compares them with a few bits from a free-running pseudo-random generator, and that comparison decides whether the base value goes up by one. Averaged over many frames, the panel shows a level that lies between two of its native steps, so the lost precision comes back in time instead of being thrown away.

The three channels read different bit fields of the same 32-bit random word. Their rounding choices are therefore uncorrelated, and a flat colour field turns into a fine, shifting speckle rather than a visible pattern. The generator steps once for each valid pixel. It stands still while the input strobe is low. Results come out through one register stage.

Top module: `tdr_dither`

## Requirements
- R1: `out_valid` in any cycle equals `in_valid` from the cycle before, so the latency is exactly one clock.
- R2: Channel packing is red in `in_pix[23:16]`, green in `in_pix[15:8]` and blue in `in_pix[7:0]`. On the output, red is `out_pix[17:12]`, green is `out_pix[11:6]` and blue is `out_pix[5:0]`. Each output channel is either its base value n (the input's bits [7:2]) or n+1.
- R3: A channel goes up by one only when its fraction (the input's bits [1:0]) is strictly greater than its 2-bit random field. A fraction of 0 therefore never causes an increment.
- R4: When n is 63, the output is 63 whatever the fraction and random field are. It never wraps to 0.
- R5: The random word is a 32-bit Fibonacci LFSR. Its feedback is the XOR of state bits 31, 21, 1 and 0, and each step shifts the state left by one with the feedback entering at bit 0. It resets to 32'h5EED_C0DE and steps once on every clock that has `in_valid` high.
- R6: The channels read the state held before the step: red reads bits [1:0], green reads bits [9:8] and blue reads bits [17:16]. Their increment patterns differ.
- R7: While `in_valid` is low, `out_pix` keeps its previous value and the random word does not step.
- R8: Synchronous active-high reset clears `out_valid` and `out_pix` to 0 and reloads the seed.
- R9: Over 256 consecutive valid pixels with a fraction of 2 in every channel, each channel goes up by one in roughly half of the pixels, within 88 to 168.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel strobe |
| in_pix | input | 24 | Input pixel, {red, green, blue} at 8 bits each |
| out_valid | output | 1 | Output pixel strobe, one clock after the input |
| out_pix | output | 18 | Output pixel, {red, green, blue} at 6 bits each |

## Verification
The bench builds the block with its default parameters: 8 input bits and 6 output bits per channel, a field stride of 8 and the stated seed. The two dropped bits then allow every fraction/random pairing (0 to 3 against 0 to 3). The input value 0xFF lands on the saturation case. The bench keeps its own model of the LFSR, so it can predict every output word exactly. That exactness covers gaps in the strobe, where neither the output nor the generator may move. It also makes it possible to compare the three channels' increment patterns against each other.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

    localparam int NUM_CH = 3;
    localparam int RND_W  = 32;

    // Feedback taps of the maximal-length generator: bits 31, 21, 1, 0
    localparam logic [RND_W-1:0] RND_TAPS = 32'h8020_0003;

    typedef enum logic [1:0] {
        CH_BLUE  = 2'd0,
        CH_GREEN = 2'd1,
        CH_RED   = 2'd2
    } chan_e;

    // Position of a channel's random field inside the random word
    function automatic int field_ofs(input int ch, input int stride);
        return (NUM_CH - 1 - ch) * stride;
    endfunction

    function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
        logic fb;
        fb = ^(s & RND_TAPS);
        return {s[RND_W-2:0], fb};
    endfunction

endpackage

// File: rtl/tdr_lfsr.sv
module tdr_lfsr
    import tdr_pkg::*;
#(
    parameter logic [RND_W-1:0] SEED = 32'h5EED_C0DE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [RND_W-1:0] state
);

    logic [RND_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SEED;
        else if (adv)
            state_q <= rnd_step(state_q);
    end

    assign state = state_q;

    // R7
    rnd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state_q));

    // R5
    rnd_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        adv |=> (state_q != '0));

endmodule

// File: rtl/tdr_chan.sv
module tdr_chan #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 6
) (
    input  logic [IN_W-1:0]        din,
    input  logic [IN_W-OUT_W-1:0]  rnd,
    output logic [OUT_W-1:0]       dout
);

    localparam int DROP_W = IN_W - OUT_W;
    localparam logic [OUT_W-1:0] TOP = {OUT_W{1'b1}};

    logic [OUT_W-1:0]  base;
    logic [DROP_W-1:0] frac;
    logic              bump;

    assign base = din[IN_W-1:DROP_W];
    assign frac = din[DROP_W-1:0];
    assign bump = (frac > rnd) && (base != TOP);

    always_comb begin
        dout = base + OUT_W'(bump);
    end

    always_comb begin
        // R3
        if (frac == '0) zero_frac_chk: assert (dout == base);
        // R4
        if (base == TOP) no_wrap_chk: assert (dout == TOP);
        // R2
        if (base != TOP) span_chk: assert ((dout == base) || (dout == base + 1'b1));
    end

endmodule

// File: rtl/tdr_dither.sv
module tdr_dither
    import tdr_pkg::*;
#(
    parameter int               CH_IN_W      = 8,
    parameter int               CH_OUT_W     = 6,
    parameter int               FIELD_STRIDE = 8,
    parameter logic [RND_W-1:0] SEED         = 32'h5EED_C0DE
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [NUM_CH*CH_IN_W-1:0]    in_pix,
    output logic                         out_valid,
    output logic [NUM_CH*CH_OUT_W-1:0]   out_pix
);

    localparam int DROP_W = CH_IN_W - CH_OUT_W;

    logic [RND_W-1:0]                     rnd_word;
    logic [NUM_CH-1:0][CH_IN_W-1:0]       pix_in_a;
    logic [NUM_CH-1:0][CH_OUT_W-1:0]      pix_nx_a;
    logic [NUM_CH-1:0][CH_OUT_W-1:0]      pix_q;
    logic                                 vld_q;

    assign pix_in_a = in_pix;

    tdr_lfsr #(.SEED(SEED)) i_rnd (
        .clk   (clk),
        .rst   (rst),
        .adv   (in_valid),
        .state (rnd_word)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int OFS = field_ofs(c, FIELD_STRIDE);
        tdr_chan #(.IN_W(CH_IN_W), .OUT_W(CH_OUT_W)) i_chan (
            .din  (pix_in_a[c]),
            .rnd  (rnd_word[OFS +: DROP_W]),
            .dout (pix_nx_a[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            pix_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid)
                pix_q <= pix_nx_a;
        end
    end

    assign out_valid = vld_q;
    assign out_pix   = pix_q;

    // R1
    vld_lat_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R1
    idle_lat_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R7
    pix_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_pix));

endmodule

// File: tb/test_tdr_dither.sv
module test_tdr_dither;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [23:0] in_pix;
    logic        out_valid;
    logic [17:0] out_pix;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] m_rnd;
    logic [17:0] m_pix;

    always #4 clk = ~clk;

    tdr_dither i_tdr_dither (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_pix    (in_pix),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

    // {valid, pixel}
    localparam logic [24:0] VEC [16] = '{
        {1'b1, 24'h000000}, {1'b1, 24'h030303}, {1'b1, 24'h818283},
        {1'b1, 24'hFFFFFF}, {1'b0, 24'h123456}, {1'b1, 24'h7F3E01},
        {1'b1, 24'hFCFDFE}, {1'b0, 24'hFFFFFF}, {1'b0, 24'h000000},
        {1'b1, 24'h404142}, {1'b1, 24'hC3C2C1}, {1'b1, 24'h010203},
        {1'b1, 24'hFEFE02}, {1'b0, 24'h555555}, {1'b1, 24'hAAAAAA},
        {1'b1, 24'h0F0F0F}
    };

    function automatic logic [31:0] m_step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic logic [5:0] m_chan(input logic [7:0] v, input logic [1:0] r);
        logic [5:0] n;
        n = v[7:2];
        if (n == 6'd63) return n;
        return (v[1:0] > r) ? n + 6'd1 : n;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at negedge, compare at the following negedge
    task automatic step(input logic v, input logic [23:0] p, input string req);
        in_valid = v;
        in_pix   = p;
        if (v) begin
            m_pix = {m_chan(p[23:16], m_rnd[1:0]),
                     m_chan(p[15:8],  m_rnd[9:8]),
                     m_chan(p[7:0],   m_rnd[17:16])};
            m_rnd = m_step(m_rnd);
        end
        @(negedge clk);
        check({req, " R1 valid"}, {31'd0, out_valid}, {31'd0, v});
        check({req, " pix"}, {14'd0, out_pix}, {14'd0, m_pix});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cnt_r, cnt_g, cnt_b, diff_rg;
        rst = 1'b1; in_valid = 1'b0; in_pix = '0;
        m_rnd = 32'h5EED_C0DE; m_pix = '0;
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 valid", {31'd0, out_valid}, 32'd0);
        check("R8 pix", {14'd0, out_pix}, 32'd0);
        rst = 1'b0;

        // R2 R3 R5 R6 R7: vector table
        for (int i = 0; i < 16; i++) begin
            step(VEC[i][24], VEC[i][23:0], "R2 R3 R5 R6 R7 table");
        end

        // R3: zero fraction never increments
        for (int i = 0; i < 20; i++) begin
            step(1'b1, 24'h545454, "R3 zero-frac");
            check("R3 zero-frac exact", {14'd0, out_pix}, {14'd0, 6'd21, 6'd21, 6'd21});
        end

        // R4: saturation at 63
        for (int i = 0; i < 20; i++) begin
            step(1'b1, 24'hFFFEFD, "R4 sat");
            check("R4 sat exact", {14'd0, out_pix}, {14'd0, 18'h3FFFF});
        end

        // R7: gap holds output, then generator resumes where it was
        step(1'b1, 24'h8A8B89, "R7 before gap");
        for (int i = 0; i < 5; i++) step(1'b0, 24'h000000, "R7 gap");
        for (int i = 0; i < 6; i++) step(1'b1, 24'h8A8B89, "R7 after gap");

        // R9 and R6: fraction 2 in every channel
        cnt_r = 0; cnt_g = 0; cnt_b = 0; diff_rg = 0;
        for (int i = 0; i < 256; i++) begin
            step(1'b1, 24'h868A8E, "R9 run");
            if (out_pix[17:12] != 6'd33) cnt_r++;
            if (out_pix[11:6]  != 6'd34) cnt_g++;
            if (out_pix[5:0]   != 6'd35) cnt_b++;
            if ((out_pix[17:12] != 6'd33) != (out_pix[11:6] != 6'd34)) diff_rg++;
        end
        check("R9 red ratio",   {31'd0, (cnt_r >= 88 && cnt_r <= 168)}, 32'd1);
        check("R9 green ratio", {31'd0, (cnt_g >= 88 && cnt_g <= 168)}, 32'd1);
        check("R9 blue ratio",  {31'd0, (cnt_b >= 88 && cnt_b <= 168)}, 32'd1);
        check("R6 channels differ", {31'd0, (diff_rg > 0)}, 32'd1);

        // R8: reset in mid-stream restores seed and clears outputs
        rst = 1'b1; in_valid = 1'b1; in_pix = 24'hFFFFFF;
        @(negedge clk);
        check("R8 mid valid", {31'd0, out_valid}, 32'd0);
        check("R8 mid pix", {14'd0, out_pix}, 32'd0);
        rst = 1'b0; m_rnd = 32'h5EED_C0DE; m_pix = '0;
        for (int i = 0; i < 8; i++) step(1'b1, 24'h818283, "R5 R8 reseed");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule